// File: doc/BRIEF.md
# Bus Master with Error Abort and Fault Capture

This block is the bus-facing half of an AHB-Lite master. A core hands it single read or write commands through a valid/ready port, and the block turns each one into a NONSEQ transfer. The address phase of the next command overlaps the data phase of the current one. Every transfer produces exactly one response, in command order, carrying the read data or an indication of what went wrong.

When a slave answers with the two-cycle ERROR response, the block uses the first error cycle to withdraw the command waiting in the address phase. In the following cycle it drives IDLE, so that command is never issued, and it is later returned to the core marked as aborted. The errored transfer itself is returned with an error flag and zeroed data. A one-cycle fault pulse goes to the core. The address and attributes of the failing access are stored in sticky fault registers, which stay set until the core pulses a clear input. A fault that arrives while the registers are still occupied sets an overflow flag and leaves the first record intact.

Top module: `ahb_err_master`

## Requirements
- R1: While reset is high and on the first cycle after it, HTRANS is IDLE (2'b00) and rsp_valid, fault, flt_valid and flt_ovf are all 0.
- R2: Every accepted command is issued once, as HTRANS=NONSEQ (2'b10). Commands are issued and answered in acceptance order. A successful transfer (HRESP=0 with HREADY=1) returns rsp_err=0 and rsp_aborted=0, with rsp_rdata equal to HRDATA for a read and 0 for a write. HWDATA carries cmd_wdata during the write's data phase.
- R3: While HREADY is low and HRESP is OKAY (0) with a NONSEQ in the address phase, HADDR, HTRANS, HWRITE, HSIZE and HPROT do not change.
- R4: The edge that ends a first ERROR cycle (HRESP=1, HREADY=0) cancels any command sitting in the address phase. HTRANS is IDLE in the next cycle, the cancelled command is never issued, and it is answered with rsp_aborted=1 and rsp_err=0 one cycle after the errored response.
- R5: A transfer that ends with HRESP=1 and HREADY=1 returns rsp_err=1, rsp_aborted=0 and rsp_rdata=0. Any bus read data is discarded.
- R6: fault is high for exactly one cycle, in the same cycle as the errored response.
- R7: When no fault is recorded, an error captures HADDR, HWRITE, HSIZE and HPROT of the failing transfer into flt_addr, flt_write, flt_size and flt_prot, and sets flt_valid.
- R8: An error that arrives while flt_valid is set leaves the captured fields unchanged and sets flt_ovf.
- R9: A flt_clr pulse clears flt_valid and flt_ovf. If flt_clr coincides with an error, the new fault is recorded and flt_ovf is 0.
- R10: After an error and any abort have been answered, the next command is issued normally as NONSEQ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken on this edge when valid |
| cmd_addr | input | AW | Command address |
| cmd_write | input | 1 | 1 = write |
| cmd_size | input | 3 | Transfer size code |
| cmd_prot | input | 4 | Protection attributes |
| cmd_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_rdata | output | DW | Read data, 0 for writes, errors and aborts |
| rsp_err | output | 1 | Transfer ended in ERROR |
| rsp_aborted | output | 1 | Command cancelled, never issued |
| haddr | output | AW | Bus address |
| htrans | output | 2 | Bus transfer type |
| hwrite | output | 1 | Bus direction |
| hsize | output | 3 | Bus size |
| hprot | output | 4 | Bus protection |
| hwdata | output | DW | Bus write data |
| hrdata | input | DW | Bus read data |
| hready | input | 1 | Transfer ready |
| hresp | input | 1 | 1 = ERROR |
| fault | output | 1 | One-cycle fault pulse to the core |
| flt_clr | input | 1 | Clears the fault record |
| flt_valid | output | 1 | Fault record holds a fault |
| flt_ovf | output | 1 | A further fault arrived while one was recorded |
| flt_addr | output | AW | Address of the recorded fault |
| flt_write | output | 1 | Direction of the recorded fault |
| flt_size | output | 3 | Size of the recorded fault |
| flt_prot | output | 4 | Protection of the recorded fault |

## Verification
The bench sweeps command streams that combine every wait-state count with errors, including two error addresses in a row. In that case the second command must come back aborted rather than errored, so a design that issued the cancelled command would show an extra bus address and a mismatched response order. A design that returned bus data on an error would show nonzero rsp_rdata, and one that let a second fault overwrite the record would show the wrong flt_addr after the sweep. A clear pulse timed onto the completion edge of an error catches a design that lets the clear win and loses the new fault.

// File: rtl/ahbm_pkg.sv
package ahbm_pkg;
  localparam logic [1:0] HT_IDLE   = 2'b00;
  localparam logic [1:0] HT_NONSEQ = 2'b10;
  localparam logic       HR_ERROR  = 1'b1;
  localparam int SIZE_W = 3;
  localparam int PROT_W = 4;
endpackage

// File: rtl/ahbm_phase_pipe.sv
module ahbm_phase_pipe
  import ahbm_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [AW-1:0]     cmd_addr,
  input  logic              cmd_write,
  input  logic [SIZE_W-1:0] cmd_size,
  input  logic [PROT_W-1:0] cmd_prot,
  input  logic [DW-1:0]     cmd_wdata,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  output logic              rsp_err,
  output logic              rsp_aborted,
  output logic [AW-1:0]     haddr,
  output logic [1:0]        htrans,
  output logic              hwrite,
  output logic [SIZE_W-1:0] hsize,
  output logic [PROT_W-1:0] hprot,
  output logic [DW-1:0]     hwdata,
  input  logic [DW-1:0]     hrdata,
  input  logic              hready,
  input  logic              hresp,
  output logic              err_done,
  output logic [AW-1:0]     dp_addr,
  output logic              dp_write,
  output logic [SIZE_W-1:0] dp_size,
  output logic [PROT_W-1:0] dp_prot
);
  // address-phase slot
  logic              ap_valid;
  logic [AW-1:0]     ap_addr;
  logic              ap_write;
  logic [SIZE_W-1:0] ap_size;
  logic [PROT_W-1:0] ap_prot;
  logic [DW-1:0]     ap_wdata;
  // data-phase slot
  logic              dp_valid;
  logic [DW-1:0]     dp_wdata;
  logic              abort_pend;

  logic err_first, ok_last, hold_off, accept, abort_emit;

  always_comb begin
    err_first  = dp_valid && (hresp == HR_ERROR) && !hready;
    err_done   = dp_valid && (hresp == HR_ERROR) && hready;
    ok_last    = dp_valid && (hresp != HR_ERROR) && hready;
    hold_off   = abort_pend || (dp_valid && (hresp == HR_ERROR));
    cmd_ready  = !hold_off && (!ap_valid || hready);
    accept     = cmd_valid && cmd_ready;
    abort_emit = abort_pend && !dp_valid;
  end

  assign htrans = ap_valid ? HT_NONSEQ : HT_IDLE;
  assign haddr  = ap_addr;
  assign hwrite = ap_write;
  assign hsize  = ap_size;
  assign hprot  = ap_prot;
  assign hwdata = dp_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      ap_valid   <= 1'b0;
      dp_valid   <= 1'b0;
      abort_pend <= 1'b0;
      ap_addr    <= '0;
      ap_write   <= 1'b0;
      ap_size    <= '0;
      ap_prot    <= '0;
      ap_wdata   <= '0;
      dp_addr    <= '0;
      dp_write   <= 1'b0;
      dp_size    <= '0;
      dp_prot    <= '0;
      dp_wdata   <= '0;
    end else begin
      if (hready) begin
        dp_valid <= ap_valid;
        dp_addr  <= ap_addr;
        dp_write <= ap_write;
        dp_size  <= ap_size;
        dp_prot  <= ap_prot;
        dp_wdata <= ap_wdata;
      end
      if (err_first) begin
        ap_valid <= 1'b0;
      end else if (accept) begin
        ap_valid <= 1'b1;
        ap_addr  <= cmd_addr;
        ap_write <= cmd_write;
        ap_size  <= cmd_size;
        ap_prot  <= cmd_prot;
        ap_wdata <= cmd_wdata;
      end else if (hready) begin
        ap_valid <= 1'b0;
      end
      if (err_first && ap_valid) abort_pend <= 1'b1;
      else if (abort_emit)       abort_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
      rsp_err     <= 1'b0;
      rsp_aborted <= 1'b0;
    end else begin
      rsp_valid   <= ok_last || err_done || abort_emit;
      rsp_rdata   <= (ok_last && !dp_write) ? hrdata : '0;
      rsp_err     <= err_done;
      rsp_aborted <= abort_emit && !ok_last && !err_done;
    end
  end

  AST_CANCEL_IDLE: assert property (@(posedge clk) disable iff (rst)
    err_first |=> (htrans == HT_IDLE)); // R4
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!hready && (hresp != HR_ERROR) && htrans == HT_NONSEQ) |=>
    ($stable(haddr) && $stable(htrans) && $stable(hwrite) && $stable(hsize) && $stable(hprot))); // R3
  AST_RSP_KIND: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($countones({rsp_err, rsp_aborted}) <= 1)); // R4
  AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && (rsp_err || rsp_aborted)) |-> (rsp_rdata == '0)); // R5
endmodule

// File: rtl/ahbm_fault_regs.sv
module ahbm_fault_regs
  import ahbm_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              err_done,
  input  logic [AW-1:0]     cap_addr,
  input  logic              cap_write,
  input  logic [SIZE_W-1:0] cap_size,
  input  logic [PROT_W-1:0] cap_prot,
  input  logic              clr,
  output logic              fault,
  output logic              flt_valid,
  output logic              flt_ovf,
  output logic [AW-1:0]     flt_addr,
  output logic              flt_write,
  output logic [SIZE_W-1:0] flt_size,
  output logic [PROT_W-1:0] flt_prot
);
  logic slot_free;
  assign slot_free = !flt_valid || clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      fault     <= 1'b0;
      flt_valid <= 1'b0;
      flt_ovf   <= 1'b0;
      flt_addr  <= '0;
      flt_write <= 1'b0;
      flt_size  <= '0;
      flt_prot  <= '0;
    end else begin
      fault <= err_done;
      if (err_done && slot_free) begin
        flt_valid <= 1'b1;
        flt_ovf   <= 1'b0;
        flt_addr  <= cap_addr;
        flt_write <= cap_write;
        flt_size  <= cap_size;
        flt_prot  <= cap_prot;
      end else if (err_done) begin
        flt_ovf   <= 1'b1;
      end else if (clr) begin
        flt_valid <= 1'b0;
        flt_ovf   <= 1'b0;
      end
    end
  end

  AST_FIRST_FAULT_KEPT: assert property (@(posedge clk) disable iff (rst)
    (flt_valid && !clr) |=> (flt_valid && $stable(flt_addr) && $stable(flt_prot))); // R8
  AST_OVF_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    flt_ovf |-> flt_valid); // R8
  AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (rst)
    fault |=> !fault); // R6
endmodule

// File: rtl/ahb_err_master.sv
module ahb_err_master
  import ahbm_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [AW-1:0]     cmd_addr,
  input  logic              cmd_write,
  input  logic [SIZE_W-1:0] cmd_size,
  input  logic [PROT_W-1:0] cmd_prot,
  input  logic [DW-1:0]     cmd_wdata,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  output logic              rsp_err,
  output logic              rsp_aborted,
  output logic [AW-1:0]     haddr,
  output logic [1:0]        htrans,
  output logic              hwrite,
  output logic [SIZE_W-1:0] hsize,
  output logic [PROT_W-1:0] hprot,
  output logic [DW-1:0]     hwdata,
  input  logic [DW-1:0]     hrdata,
  input  logic              hready,
  input  logic              hresp,
  output logic              fault,
  input  logic              flt_clr,
  output logic              flt_valid,
  output logic              flt_ovf,
  output logic [AW-1:0]     flt_addr,
  output logic              flt_write,
  output logic [SIZE_W-1:0] flt_size,
  output logic [PROT_W-1:0] flt_prot
);
  logic              err_done;
  logic [AW-1:0]     dp_addr;
  logic              dp_write;
  logic [SIZE_W-1:0] dp_size;
  logic [PROT_W-1:0] dp_prot;

  ahbm_phase_pipe #(.AW(AW), .DW(DW)) u_pipe (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_write(cmd_write), .cmd_size(cmd_size), .cmd_prot(cmd_prot),
    .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .rsp_aborted(rsp_aborted),
    .haddr(haddr), .htrans(htrans), .hwrite(hwrite), .hsize(hsize),
    .hprot(hprot), .hwdata(hwdata), .hrdata(hrdata), .hready(hready),
    .hresp(hresp),
    .err_done(err_done), .dp_addr(dp_addr), .dp_write(dp_write),
    .dp_size(dp_size), .dp_prot(dp_prot)
  );

  ahbm_fault_regs #(.AW(AW)) u_fault (
    .clk(clk), .rst(rst),
    .err_done(err_done), .cap_addr(dp_addr), .cap_write(dp_write),
    .cap_size(dp_size), .cap_prot(dp_prot), .clr(flt_clr),
    .fault(fault), .flt_valid(flt_valid), .flt_ovf(flt_ovf),
    .flt_addr(flt_addr), .flt_write(flt_write), .flt_size(flt_size),
    .flt_prot(flt_prot)
  );

  AST_FAULT_WITH_ERR: assert property (@(posedge clk) disable iff (rst)
    fault |-> (rsp_valid && rsp_err)); // R6
endmodule

// File: tb/ahb_err_master_tb_top.sv
module ahb_err_master_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0, cmd_ready;
  logic [31:0] cmd_addr = '0, cmd_wdata = '0;
  logic        cmd_write = 1'b0;
  logic [2:0]  cmd_size = '0;
  logic [3:0]  cmd_prot = '0;
  logic        rsp_valid, rsp_err, rsp_aborted;
  logic [31:0] rsp_rdata, haddr, hwdata, flt_addr;
  logic [31:0] hrdata;
  logic [1:0]  htrans;
  logic        hwrite, hready, hresp, fault, flt_valid, flt_ovf, flt_write;
  logic [2:0]  hsize, flt_size;
  logic [3:0]  hprot, flt_prot;
  logic        flt_clr = 1'b0;

  ahb_err_master #(.AW(32), .DW(32)) dut_i (.*);

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // command plan and expectations (kind: 0 ok, 1 error, 2 aborted)
  logic [31:0] c_addr [64];
  logic        c_write[64];
  logic [2:0]  c_size [64];
  logic [3:0]  c_prot [64];
  logic [1:0]  e_kind [64];
  logic [31:0] e_iss  [64];
  int n_cmd = 0, n_iss = 0, rsp_idx = 0, iss_idx = 0, fault_cnt = 0;

  function automatic logic [31:0] rd_of(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h5A5A_5A5A;
  endfunction

  task automatic fill_sweep();
    n_cmd = 24;
    for (int i = 0; i < 24; i++) begin
      logic er;
      er = (i % 5 == 1) || (i % 5 == 2);
      c_addr[i]  = 32'h1000_0000 | (32'(i) << 12) | (32'(er) << 8) | (32'(i % 4) << 4);
      c_write[i] = i[0];
      c_size[i]  = 3'(i % 3);
      c_prot[i]  = 4'(i % 16);
    end
  endtask

  task automatic plan(input bit back2back);
    bit pe = 1'b0;
    n_iss = 0; rsp_idx = 0; iss_idx = 0; fault_cnt = 0;
    for (int i = 0; i < n_cmd; i++) begin
      if (back2back && pe) begin
        e_kind[i] = 2'd2; pe = 1'b0;
      end else begin
        e_kind[i] = c_addr[i][8] ? 2'd1 : 2'd0;
        e_iss[n_iss] = c_addr[i]; n_iss++;
        pe = c_addr[i][8];
      end
    end
  endtask

  task automatic send(input int i);
    cmd_addr = c_addr[i]; cmd_write = c_write[i]; cmd_size = c_size[i];
    cmd_prot = c_prot[i]; cmd_wdata = ~c_addr[i]; cmd_valid = 1'b1;
    forever begin
      #1;
      if (cmd_ready) break;
      @(negedge clk);
    end
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_rsp(input int upto, input bit clr_at_err);
    forever begin
      if (rsp_idx > upto) break;
      flt_clr = clr_at_err && hready && hresp;
      @(negedge clk); #2;
    end
    flt_clr = 1'b0;
  endtask

  task automatic check_record(input string tag);
    int first = -1, errs = 0;
    for (int i = 0; i < n_cmd; i++)
      if (e_kind[i] == 2'd1) begin errs++; if (first < 0) first = i; end
    chk(fault_cnt == errs, "R6", {tag, " fault pulse count"}, 32'(fault_cnt), 32'(errs));
    chk(rsp_idx == n_cmd, "R2", {tag, " response count"}, 32'(rsp_idx), 32'(n_cmd));
    chk(iss_idx == n_iss, "R4", {tag, " issued count"}, 32'(iss_idx), 32'(n_iss));
    chk(flt_valid == 1'b1, "R7", {tag, " flt_valid"}, 32'(flt_valid), 32'd1);
    chk(flt_addr == c_addr[first], "R7", {tag, " flt_addr"}, flt_addr, c_addr[first]);
    chk({flt_write, flt_size, flt_prot} == {c_write[first], c_size[first], c_prot[first]},
        "R7", {tag, " flt attributes"}, 32'({flt_write, flt_size, flt_prot}),
        32'({c_write[first], c_size[first], c_prot[first]}));
    chk(flt_ovf == (errs > 1), "R8", {tag, " flt_ovf"}, 32'(flt_ovf), 32'(errs > 1));
  endtask

  // slave model: waits from addr[5:4], error when addr[8] is set
  logic        s_act, s_write, s_err;
  logic [1:0]  s_rem;
  logic [31:0] s_addr, p_addr;
  logic        p_wait;
  logic [1:0]  p_tr;
  always @(posedge clk) begin
    if (rst) begin
      hready <= 1'b1; hresp <= 1'b0; hrdata <= '0; s_act <= 1'b0;
      s_write <= 1'b0; s_err <= 1'b0; s_rem <= '0; s_addr <= '0; p_wait <= 1'b0;
    end else begin
      if (p_wait)
        chk(haddr == p_addr && htrans == p_tr, "R3", "address held in wait", haddr, p_addr);
      p_wait <= !hready && !hresp && htrans == 2'b10;
      p_addr <= haddr; p_tr <= htrans;
      if (hready) begin
        if (s_act && s_write && !hresp)
          chk(hwdata == ~s_addr, "R2", "write data", hwdata, ~s_addr);
        if (htrans == 2'b10) begin
          chk(iss_idx < n_iss && haddr == e_iss[iss_idx & 63], "R4/R10", "issued address",
              haddr, e_iss[iss_idx & 63]);
          iss_idx++;
          s_act <= 1'b1; s_addr <= haddr; s_write <= hwrite; s_err <= haddr[8];
          if (haddr[5:4] != 0) begin
            hready <= 1'b0; hresp <= 1'b0; s_rem <= haddr[5:4] - 2'd1;
          end else if (haddr[8]) begin
            hready <= 1'b0; hresp <= 1'b1;
          end else begin
            hready <= 1'b1; hresp <= 1'b0; hrdata <= rd_of(haddr);
          end
        end else begin
          s_act <= 1'b0; hready <= 1'b1; hresp <= 1'b0;
        end
      end else if (hresp) begin
        hready <= 1'b1; hresp <= 1'b1; hrdata <= 32'hDEAD_BEEF;
      end else if (s_rem != 0) begin
        s_rem <= s_rem - 2'd1;
      end else if (s_err) begin
        hresp <= 1'b1;
      end else begin
        hready <= 1'b1; hrdata <= rd_of(s_addr);
      end
    end
  end

  // response and fault monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (rsp_valid) begin
        if (rsp_idx < n_cmd) begin
          case (e_kind[rsp_idx])
            2'd2: chk(rsp_aborted && !rsp_err, "R4", "aborted response",
                      32'({rsp_err, rsp_aborted}), 32'b01);
            2'd1: begin
              chk(rsp_err && !rsp_aborted, "R5", "error response",
                  32'({rsp_err, rsp_aborted}), 32'b10);
              chk(rsp_rdata == '0, "R5", "discarded data", rsp_rdata, 32'd0);
            end
            default: begin
              chk(!rsp_err && !rsp_aborted, "R2", "okay response",
                  32'({rsp_err, rsp_aborted}), 32'b00);
              chk(rsp_rdata == (c_write[rsp_idx] ? 32'd0 : rd_of(c_addr[rsp_idx])),
                  "R2", "read data", rsp_rdata,
                  c_write[rsp_idx] ? 32'd0 : rd_of(c_addr[rsp_idx]));
            end
          endcase
        end else begin
          chk(1'b0, "R2", "unexpected response", 32'(rsp_idx), 32'(n_cmd));
        end
        rsp_idx++;
      end
      if (fault) begin
        fault_cnt++;
        chk(rsp_valid && rsp_err, "R6", "fault with error response",
            32'({rsp_valid, rsp_err}), 32'b11);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(htrans == 2'b00, "R1", "htrans in reset", 32'(htrans), 32'd0);
    chk({rsp_valid, fault, flt_valid, flt_ovf} == 4'b0, "R1", "outputs in reset",
        32'({rsp_valid, fault, flt_valid, flt_ovf}), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(htrans == 2'b00 && !rsp_valid && !flt_valid, "R1", "idle after reset",
        32'({htrans, rsp_valid, flt_valid}), 32'd0);

    // sweep 1: back-to-back stream, errors cancel the queued follow-on (R4, R10)
    fill_sweep(); plan(1'b1);
    for (int i = 0; i < n_cmd; i++) send(i);
    wait_rsp(n_cmd - 1, 1'b0);
    repeat (3) @(negedge clk);
    check_record("stream");

    // R9: clear pulse
    flt_clr = 1'b1; @(negedge clk); flt_clr = 1'b0; @(negedge clk);
    chk(!flt_valid && !flt_ovf, "R9", "record cleared", 32'({flt_valid, flt_ovf}), 32'd0);

    // sweep 2: spaced commands, nothing cancelled, errors back to back (R8)
    fill_sweep(); plan(1'b0);
    for (int i = 0; i < n_cmd; i++) begin send(i); wait_rsp(i, 1'b0); end
    repeat (3) @(negedge clk);
    check_record("spaced");

    // sweep 3: clear lands on the completion edge of a new error (R9)
    n_cmd = 1;
    c_addr[0] = 32'h2000_0120; c_write[0] = 1'b0; c_size[0] = 3'd2; c_prot[0] = 4'hA;
    plan(1'b0);
    send(0); wait_rsp(0, 1'b1);
    repeat (2) @(negedge clk);
    chk(flt_valid && !flt_ovf, "R9", "clear with error keeps new fault",
        32'({flt_valid, flt_ovf}), 32'b10);
    chk(flt_addr == 32'h2000_0120, "R9", "new fault address", flt_addr, 32'h2000_0120);
    chk({flt_write, flt_size, flt_prot} == {1'b0, 3'd2, 4'hA}, "R9", "new fault attributes",
        32'({flt_write, flt_size, flt_prot}), 32'({1'b0, 3'd2, 4'hA}));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule